// File: doc/BRIEF.md
# Endpoint Handshake Register Bank

This block is the per-endpoint register bank of a USB device controller. It holds each endpoint's control word, its sticky event status, an interrupt mask and its packet-size word. There are four IN endpoints and three OUT endpoints that have storage. The OUT slot at index 2 owns no registers, and every access to it lands on OUT endpoint 0. Software reaches the bank through a plain single-cycle register bus. Read data is combinational on the address, and a write takes effect at the clock edge.

The packet engine presents each token with its direction, endpoint and SETUP flag. The bank answers at once with ACK, NAK or STALL, based on the endpoint's stall, active and NAK state. The NAK state cannot be written as a field. It is raised and dropped through two strobe bits in the control word, and hardware raises it again after every finished transfer. The engine's DMA side reports events that set sticky status bits. Any status bit that is not masked raises that endpoint's interrupt line. A flush request in the control word becomes a single-cycle pulse toward the FIFO of that endpoint.

Top module: `ep_hs_bank`

## Requirements
- R1: Word address = {dir (1 = OUT), endpoint index, register select}, with register select 0 = control, 1 = status, 2 = mask, 3 = packet size. After reset, every control word reads 0x40 (NAK set, all else 0), and status, mask and packet size read 0.
- R2: Control word: bit0 stall, bit3 poll demand, bits 5:4 type and bit10 active are read/write. Bit6 shows NAK and is read-only. Bits 1, 7 and 8 always read 0.
- R3: Writing a control word with bit7 set raises NAK. Bit8 clears NAK. If both are written together, NAK ends up set.
- R4: A transfer-done report for an endpoint sets its NAK at the next edge. If it falls in the same cycle as a clear-NAK write, NAK stays set.
- R5: Status bits 4, 5, 6, 7, 9 and 10 are set by an event word that carries a 1 in that position, and they hold until software writes 1 to them. All other status bits read 0. An event and a clearing write to the same bit in one cycle leave the bit at 1.
- R6: The mask register stores the same six bit positions. An endpoint's interrupt line (bit n of inIrq/outIrq) is high exactly when some status bit is set and its mask bit is 0.
- R7: The packet-size word keeps bits 10:0 on every endpoint. OUT endpoints also keep bits 31:23 as the receive FIFO size. On IN endpoints those bits read 0.
- R8: On the OUT side, index 2 is an alias of index 0 for reads, writes, events, done reports and tokens. outIrq[2] is always 0.
- R9: The handshake code is 0 = ACK, 1 = NAK, 2 = STALL. A SETUP token on OUT endpoint 0 always gets ACK. Otherwise a set stall bit gives STALL. Failing that, an inactive endpoint or one with NAK set gives NAK, and any other case gives ACK.
- R10: A control write with bit1 set drives that endpoint's flush output high for exactly the one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Word address {dir, ep, sel} |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe |
| busRdata | output | 32 | Read data for busAddr |
| evValid | input | 1 | Status event valid |
| evOut | input | 1 | Event direction (1 = OUT) |
| evEp | input | 2 | Event endpoint |
| evBits | input | 32 | Status bits to set |
| doneValid | input | 1 | Transfer-done report valid |
| doneOut | input | 1 | Done direction (1 = OUT) |
| doneEp | input | 2 | Done endpoint |
| tokValid | input | 1 | Token present |
| tokOut | input | 1 | Token direction (1 = OUT/SETUP) |
| tokSetup | input | 1 | Token is SETUP |
| tokEp | input | 2 | Token endpoint |
| hsCode | output | 2 | Handshake answer |
| inIrq | output | 4 | IN endpoint interrupt lines |
| outIrq | output | 4 | OUT endpoint interrupt lines |
| inFlush | output | 4 | IN FIFO flush pulses |
| outFlush | output | 4 | OUT FIFO flush pulses |

## Verification
Two pairs of functions can collide in one cycle. A hardware event can set a status bit in the same cycle that software writes 1 to clear it, and a transfer-done report can raise NAK in the same cycle that software writes clear-NAK. The bench drives each pair on one clock edge, reads the affected word back on the next cycle, and requires the hardware side to win. Aliasing is judged by writing or raising events through OUT index 2 and observing the effect at OUT index 0, on outIrq bit 0 and in the handshake.

// File: rtl/ep_hs_pkg.sv
`timescale 1ns/1ps
package ep_hs_pkg;
  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hs_e;

  // Strobes the control decoder hands to the register datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrSts;
    logic wrMask;
    logic wrMpk;
    logic setNak;
    logic clrNak;
    logic flush;
    logic isOut;
  } regStb_t;

  localparam int DATA_W   = 32;
  localparam int CB_STALL = 0;
  localparam int CB_FLUSH = 1;
  localparam int CB_POLL  = 3;
  localparam int CB_TYPE  = 4;
  localparam int CB_NAK   = 6;
  localparam int CB_SNAK  = 7;
  localparam int CB_CNAK  = 8;
  localparam int CB_ACT   = 10;
  localparam logic [DATA_W-1:0] STS_LIVE = 32'h0000_06F0;
  localparam int MPK_W    = 11;
  localparam int FSZ_LSB  = 23;
  localparam int FSZ_W    = 9;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STS  = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;
  localparam logic [1:0] SEL_MPK  = 2'd3;
endpackage

// File: rtl/ep_hs_ctrl.sv
`timescale 1ns/1ps
module ep_hs_ctrl
  import ep_hs_pkg::*;
#(
  parameter int NUM_EP    = 4,
  parameter int ALIAS_IDX = 2,
  parameter int ALIAS_TGT = 0,
  localparam int EPW      = $clog2(NUM_EP),
  localparam int ADDR_W   = 1 + EPW + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        cmdBits,   // {clear-NAK, set-NAK, flush}
  input  logic              busWe,
  input  logic              evOut,
  input  logic [EPW-1:0]    evEp,
  input  logic              doneOut,
  input  logic [EPW-1:0]    doneEp,
  input  logic              tokValid,
  input  logic              tokOut,
  input  logic              tokSetup,
  input  logic [EPW-1:0]    tokEp,
  input  logic [NUM_EP-1:0] inStall,
  input  logic [NUM_EP-1:0] inAct,
  input  logic [NUM_EP-1:0] inNak,
  input  logic [NUM_EP-1:0] outStall,
  input  logic [NUM_EP-1:0] outAct,
  input  logic [NUM_EP-1:0] outNak,
  output regStb_t           stb,
  output logic [EPW-1:0]    stbEp,
  output logic              rdOut,
  output logic [EPW-1:0]    rdEp,
  output logic [1:0]        rdSel,
  output logic [EPW-1:0]    evEpN,
  output logic [EPW-1:0]    doneEpN,
  output logic [1:0]        hsCode
);

  function automatic logic [EPW-1:0] normEp(input logic isOut, input logic [EPW-1:0] ep);
    return (isOut && ep == EPW'(ALIAS_IDX)) ? EPW'(ALIAS_TGT) : ep;
  endfunction

  logic          addrOut;
  logic [EPW-1:0] addrEp;
  logic [1:0]    addrSel;

  assign addrOut = busAddr[ADDR_W-1];
  assign addrEp  = busAddr[2 +: EPW];
  assign addrSel = busAddr[1:0];

  assign rdOut   = addrOut;
  assign rdEp    = normEp(addrOut, addrEp);
  assign rdSel   = addrSel;
  assign stbEp   = rdEp;
  assign evEpN   = normEp(evOut, evEp);
  assign doneEpN = normEp(doneOut, doneEp);

  always_comb begin
    stb        = '0;
    stb.isOut  = addrOut;
    stb.wrCtrl = busWe && addrSel == SEL_CTRL;
    stb.wrSts  = busWe && addrSel == SEL_STS;
    stb.wrMask = busWe && addrSel == SEL_MASK;
    stb.wrMpk  = busWe && addrSel == SEL_MPK;
    stb.setNak = stb.wrCtrl && cmdBits[1];
    stb.clrNak = stb.wrCtrl && cmdBits[2] && !cmdBits[1];
    stb.flush  = stb.wrCtrl && cmdBits[0];
  end

  // Handshake decision for the token on the bus
  logic [EPW-1:0] tEp;
  logic           tStall, tAct, tNak;
  hs_e            hsNext;

  assign tEp    = normEp(tokOut, tokEp);
  assign tStall = tokOut ? outStall[tEp] : inStall[tEp];
  assign tAct   = tokOut ? outAct[tEp]   : inAct[tEp];
  assign tNak   = tokOut ? outNak[tEp]   : inNak[tEp];

  always_comb begin
    if (!tokValid)                                  hsNext = HS_ACK;
    else if (tokSetup && tokOut && tEp == '0)       hsNext = HS_ACK;
    else if (tStall)                                hsNext = HS_STALL;
    else if (!tAct || tNak)                         hsNext = HS_NAK;
    else                                            hsNext = HS_ACK;
  end
  assign hsCode = hsNext;

  AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (tokValid && tokSetup && tokOut && (tokEp == '0 || tokEp == EPW'(ALIAS_IDX)))
      |-> hsCode == HS_ACK); // R9
  AST_HS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    hsCode != 2'd3); // R9
endmodule

// File: rtl/ep_hs_regfile.sv
`timescale 1ns/1ps
module ep_hs_regfile
  import ep_hs_pkg::*;
#(
  parameter int NUM_EP    = 4,
  parameter int ALIAS_IDX = 2,
  localparam int EPW      = $clog2(NUM_EP),
  localparam int SLOTS    = 2 * NUM_EP
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStb_t           stb,
  input  logic [EPW-1:0]    stbEp,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rdOut,
  input  logic [EPW-1:0]    rdEp,
  input  logic [1:0]        rdSel,
  input  logic              evValid,
  input  logic              evOut,
  input  logic [EPW-1:0]    evEpN,
  input  logic [DATA_W-1:0] evBits,
  input  logic              doneValid,
  input  logic              doneOut,
  input  logic [EPW-1:0]    doneEpN,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_EP-1:0] inStall,
  output logic [NUM_EP-1:0] inAct,
  output logic [NUM_EP-1:0] inNak,
  output logic [NUM_EP-1:0] outStall,
  output logic [NUM_EP-1:0] outAct,
  output logic [NUM_EP-1:0] outNak,
  output logic [NUM_EP-1:0] inIrq,
  output logic [NUM_EP-1:0] outIrq,
  output logic [NUM_EP-1:0] inFlush,
  output logic [NUM_EP-1:0] outFlush
);

  logic [SLOTS-1:0]  slotStall, slotAct, slotNak, slotIrq, slotFlush;
  logic [DATA_W-1:0] ctrlW [SLOTS];
  logic [DATA_W-1:0] stsW  [SLOTS];
  logic [DATA_W-1:0] maskW [SLOTS];
  logic [DATA_W-1:0] mpkW  [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam bit IS_OUT = (k >= NUM_EP);
    localparam int EI     = k % NUM_EP;
    if (IS_OUT && EI == ALIAS_IDX) begin : g_alias
      assign slotStall[k] = 1'b0;
      assign slotAct[k]   = 1'b0;
      assign slotNak[k]   = 1'b0;
      assign slotIrq[k]   = 1'b0;
      assign slotFlush[k] = 1'b0;
      assign ctrlW[k]     = '0;
      assign stsW[k]      = '0;
      assign maskW[k]     = '0;
      assign mpkW[k]      = '0;
    end else begin : g_real
      logic              stall, poll, act, nak, flushQ;
      logic [1:0]        epType;
      logic [DATA_W-1:0] sts, mask;
      logic [MPK_W-1:0]  mpk;
      logic [FSZ_W-1:0]  fsz;
      logic              hit, evHit, doneHit;

      assign hit     = (stb.isOut == IS_OUT) && (stbEp == EPW'(EI));
      assign evHit   = evValid && (evOut == IS_OUT) && (evEpN == EPW'(EI));
      assign doneHit = doneValid && (doneOut == IS_OUT) && (doneEpN == EPW'(EI));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          stall  <= 1'b0;
          poll   <= 1'b0;
          act    <= 1'b0;
          epType <= '0;
          nak    <= 1'b1;
          sts    <= '0;
          mask   <= '0;
          mpk    <= '0;
          fsz    <= '0;
          flushQ <= 1'b0;
        end else begin
          if (hit && stb.wrCtrl) begin
            stall  <= wdata[CB_STALL];
            poll   <= wdata[CB_POLL];
            epType <= wdata[CB_TYPE +: 2];
            act    <= wdata[CB_ACT];
          end
          if (doneHit || (hit && stb.setNak)) nak <= 1'b1;
          else if (hit && stb.clrNak)         nak <= 1'b0;
          sts <= (sts & ~((hit && stb.wrSts) ? (wdata & STS_LIVE) : '0))
               | (evHit ? (evBits & STS_LIVE) : '0);
          if (hit && stb.wrMask) mask <= wdata & STS_LIVE;
          if (hit && stb.wrMpk) begin
            mpk <= wdata[MPK_W-1:0];
            fsz <= IS_OUT ? wdata[FSZ_LSB +: FSZ_W] : '0;
          end
          flushQ <= hit && stb.flush;
        end
      end

      assign slotStall[k] = stall;
      assign slotAct[k]   = act;
      assign slotNak[k]   = nak;
      assign slotIrq[k]   = |(sts & ~mask);
      assign slotFlush[k] = flushQ;
      always_comb begin
        ctrlW[k]              = '0;
        ctrlW[k][CB_STALL]    = stall;
        ctrlW[k][CB_POLL]     = poll;
        ctrlW[k][CB_TYPE +: 2] = epType;
        ctrlW[k][CB_NAK]      = nak;
        ctrlW[k][CB_ACT]      = act;
        mpkW[k]               = '0;
        mpkW[k][MPK_W-1:0]    = mpk;
        mpkW[k][FSZ_LSB +: FSZ_W] = fsz;
      end
      assign stsW[k]  = sts;
      assign maskW[k] = mask;

      AST_DONE_NAK: assert property (@(posedge clk) disable iff (!rstN)
        doneHit |=> nak); // R4
      AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        !$past(hit && stb.wrSts) |-> ((sts & $past(sts)) == $past(sts))); // R5
    end
  end

  assign inStall  = slotStall[NUM_EP-1:0];
  assign outStall = slotStall[SLOTS-1:NUM_EP];
  assign inAct    = slotAct[NUM_EP-1:0];
  assign outAct   = slotAct[SLOTS-1:NUM_EP];
  assign inNak    = slotNak[NUM_EP-1:0];
  assign outNak   = slotNak[SLOTS-1:NUM_EP];
  assign inIrq    = slotIrq[NUM_EP-1:0];
  assign outIrq   = slotIrq[SLOTS-1:NUM_EP];
  assign inFlush  = slotFlush[NUM_EP-1:0];
  assign outFlush = slotFlush[SLOTS-1:NUM_EP];

  logic [EPW:0] rdIdx;
  assign rdIdx = {rdOut, rdEp};

  always_comb begin
    case (rdSel)
      SEL_CTRL: rdata = ctrlW[rdIdx];
      SEL_STS:  rdata = stsW[rdIdx];
      SEL_MASK: rdata = maskW[rdIdx];
      default:  rdata = mpkW[rdIdx];
    endcase
  end
endmodule

// File: rtl/ep_hs_bank.sv
`timescale 1ns/1ps
module ep_hs_bank
  import ep_hs_pkg::*;
#(
  parameter int NUM_EP    = 4,
  parameter int ALIAS_IDX = 2,
  parameter int ALIAS_TGT = 0,
  localparam int EPW      = $clog2(NUM_EP),
  localparam int ADDR_W   = 1 + EPW + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  output logic [31:0]       busRdata,
  input  logic              evValid,
  input  logic              evOut,
  input  logic [EPW-1:0]    evEp,
  input  logic [31:0]       evBits,
  input  logic              doneValid,
  input  logic              doneOut,
  input  logic [EPW-1:0]    doneEp,
  input  logic              tokValid,
  input  logic              tokOut,
  input  logic              tokSetup,
  input  logic [EPW-1:0]    tokEp,
  output logic [1:0]        hsCode,
  output logic [NUM_EP-1:0] inIrq,
  output logic [NUM_EP-1:0] outIrq,
  output logic [NUM_EP-1:0] inFlush,
  output logic [NUM_EP-1:0] outFlush
);

  regStb_t        stb;
  logic [EPW-1:0] stbEp, rdEp, evEpN, doneEpN;
  logic           rdOut;
  logic [1:0]     rdSel;
  logic [NUM_EP-1:0] inStall, inAct, inNak, outStall, outAct, outNak;

  ep_hs_ctrl #(.NUM_EP(NUM_EP), .ALIAS_IDX(ALIAS_IDX), .ALIAS_TGT(ALIAS_TGT)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .cmdBits({busWdata[CB_CNAK], busWdata[CB_SNAK], busWdata[CB_FLUSH]}),
    .busWe(busWe), .evOut(evOut), .evEp(evEp), .doneOut(doneOut), .doneEp(doneEp),
    .tokValid(tokValid), .tokOut(tokOut), .tokSetup(tokSetup), .tokEp(tokEp),
    .inStall(inStall), .inAct(inAct), .inNak(inNak),
    .outStall(outStall), .outAct(outAct), .outNak(outNak),
    .stb(stb), .stbEp(stbEp), .rdOut(rdOut), .rdEp(rdEp), .rdSel(rdSel),
    .evEpN(evEpN), .doneEpN(doneEpN), .hsCode(hsCode)
  );

  ep_hs_regfile #(.NUM_EP(NUM_EP), .ALIAS_IDX(ALIAS_IDX)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .stbEp(stbEp), .wdata(busWdata),
    .rdOut(rdOut), .rdEp(rdEp), .rdSel(rdSel),
    .evValid(evValid), .evOut(evOut), .evEpN(evEpN), .evBits(evBits),
    .doneValid(doneValid), .doneOut(doneOut), .doneEpN(doneEpN),
    .rdata(busRdata),
    .inStall(inStall), .inAct(inAct), .inNak(inNak),
    .outStall(outStall), .outAct(outAct), .outNak(outNak),
    .inIrq(inIrq), .outIrq(outIrq), .inFlush(inFlush), .outFlush(outFlush)
  );

  AST_FLUSH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (|inFlush) |-> $past(busWe && busWdata[CB_FLUSH] && !busAddr[ADDR_W-1]
                         && busAddr[1:0] == SEL_CTRL)); // R10
  AST_FLUSH_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inFlush, outFlush})); // R10
endmodule

// File: tb/ep_hs_bank_tb.sv
`timescale 1ns/1ps
module ep_hs_bank_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  busAddr;
  logic [31:0] busWdata;
  logic        busWe;
  logic [31:0] busRdata;
  logic        evValid, evOut;
  logic [1:0]  evEp;
  logic [31:0] evBits;
  logic        doneValid, doneOut;
  logic [1:0]  doneEp;
  logic        tokValid, tokOut, tokSetup;
  logic [1:0]  tokEp;
  logic [1:0]  hsCode;
  logic [3:0]  inIrq, outIrq, inFlush, outFlush;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ep_hs_bank u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .busRdata(busRdata), .evValid(evValid), .evOut(evOut), .evEp(evEp), .evBits(evBits),
    .doneValid(doneValid), .doneOut(doneOut), .doneEp(doneEp),
    .tokValid(tokValid), .tokOut(tokOut), .tokSetup(tokSetup), .tokEp(tokEp),
    .hsCode(hsCode), .inIrq(inIrq), .outIrq(outIrq), .inFlush(inFlush), .outFlush(outFlush)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  function automatic logic [4:0] A(input bit o, input int ep, input int sel);
    return {o, 2'(ep), 2'(sel)};
  endfunction

  task automatic push(input int sel, input logic [31:0] exp, input string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = busRdata;
        1: act = {30'b0, hsCode};
        2: act = {28'b0, inIrq};
        3: act = {28'b0, outIrq};
        4: act = {28'b0, inFlush};
        default: act = {28'b0, outFlush};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    busWe = 0; evValid = 0; doneValid = 0; tokValid = 0; tokSetup = 0;
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cyc(); busWe = 1; busAddr = a; busWdata = d;
  endtask
  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    cyc(); busAddr = a; push(0, exp, tag);
  endtask
  task automatic ev(input bit o, input int ep, input logic [31:0] b);
    cyc(); evValid = 1; evOut = o; evEp = 2'(ep); evBits = b;
  endtask
  task automatic tok(input bit o, input bit s, input int ep, input logic [1:0] exp, input string tag);
    cyc(); tokValid = 1; tokOut = o; tokSetup = s; tokEp = 2'(ep); push(1, {30'b0, exp}, tag);
  endtask

  initial begin
    #300000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; busAddr = 0; busWdata = 0; busWe = 0;
    evValid = 0; evOut = 0; evEp = 0; evBits = 0;
    doneValid = 0; doneOut = 0; doneEp = 0;
    tokValid = 0; tokOut = 0; tokSetup = 0; tokEp = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    rd(A(0,1,0), 32'h40, "R1 IN1 ctrl reset");
    push(2, 0, "R1 inIrq reset");
    rd(A(1,3,3), 32'h0, "R1 OUT3 size reset");
    rd(A(0,0,1), 32'h0, "R1 IN0 status reset");

    // R2 control field layout
    wr(A(0,1,0), 32'h0000_0439);
    rd(A(0,1,0), 32'h479, "R2 IN1 ctrl fields");

    // R3 NAK strobes, R9 handshake
    wr(A(0,1,0), 32'h500);
    rd(A(0,1,0), 32'h400, "R3 clear-NAK");
    tok(0, 0, 1, 2'd0, "R9 active ACK");
    wr(A(0,1,0), 32'h580);
    rd(A(0,1,0), 32'h440, "R3 both strobes set wins");
    tok(0, 0, 1, 2'd1, "R9 NAK set");
    wr(A(0,1,0), 32'h501);
    rd(A(0,1,0), 32'h401, "R2 stall bit");
    tok(0, 0, 1, 2'd2, "R9 stall");
    wr(A(0,1,0), 32'h500);
    wr(A(0,1,0), 32'h480);
    rd(A(0,1,0), 32'h440, "R3 set-NAK");

    // R4 transfer done re-asserts NAK
    wr(A(0,1,0), 32'h500);
    cyc(); doneValid = 1; doneOut = 0; doneEp = 1;
    rd(A(0,1,0), 32'h440, "R4 done sets NAK");
    wr(A(0,1,0), 32'h500);
    wr(A(0,1,0), 32'h500); doneValid = 1; doneOut = 0; doneEp = 1;
    rd(A(0,1,0), 32'h440, "R4 done beats clear-NAK");

    // R9 inactive and SETUP rules, R8 alias tokens
    tok(0, 0, 2, 2'd1, "R9 inactive NAK");
    tok(1, 1, 0, 2'd0, "R9 SETUP ep0 ACK");
    wr(A(1,0,0), 32'h401);
    rd(A(1,2,0), 32'h441, "R8 alias reads OUT0 ctrl");
    tok(1, 1, 2, 2'd0, "R8 R9 SETUP via alias ACK");
    tok(1, 0, 0, 2'd2, "R9 OUT0 stall");
    tok(1, 0, 2, 2'd2, "R8 alias token stall");

    // R5 sticky status, W1C, event wins
    ev(0, 3, 32'hFFFF_FFFF);
    rd(A(0,3,1), 32'h6F0, "R5 status set");
    push(2, 32'h8, "R6 irq IN3");
    wr(A(0,3,1), 32'h10);
    rd(A(0,3,1), 32'h6E0, "R5 W1C bit4");
    wr(A(0,3,1), 32'h20); evValid = 1; evOut = 0; evEp = 3; evBits = 32'h20;
    rd(A(0,3,1), 32'h6E0, "R5 event beats clear");
    wr(A(0,3,1), 32'hFFFF_FFFF);
    rd(A(0,3,1), 32'h0, "R5 clear all");
    push(2, 32'h0, "R6 irq off");

    // R6 mask
    wr(A(0,3,2), 32'hFFFF_FFFF);
    rd(A(0,3,2), 32'h6F0, "R6 mask bits");
    wr(A(0,3,2), 32'h400);
    ev(0, 3, 32'h400);
    rd(A(0,3,1), 32'h400, "R6 status when masked");
    push(2, 32'h0, "R6 masked no irq");
    ev(0, 3, 32'h10);
    rd(A(0,3,1), 32'h410, "R6 status unmasked bit");
    push(2, 32'h8, "R6 unmasked irq");
    wr(A(0,3,1), 32'hFFFF_FFFF);

    // R7 packet size
    wr(A(1,1,3), 32'hFFFF_FFFF);
    rd(A(1,1,3), 32'hFF80_07FF, "R7 OUT size+fifo");
    wr(A(0,0,3), 32'hFFFF_FFFF);
    rd(A(0,0,3), 32'h0000_07FF, "R7 IN size only");

    // R8 alias events
    ev(1, 2, 32'h20);
    rd(A(1,0,1), 32'h20, "R8 alias event on OUT0");
    push(3, 32'h1, "R8 outIrq bit0 only");
    wr(A(1,2,1), 32'h20);
    rd(A(1,0,1), 32'h0, "R8 alias clear");

    // R10 flush pulse
    wr(A(0,2,0), 32'h2);
    push(4, 32'h0, "R10 no pulse in write cycle");
    cyc(); push(4, 32'h4, "R10 IN2 flush pulse");
    cyc(); push(4, 32'h0, "R10 pulse one cycle");
    rd(A(0,2,0), 32'h40, "R10 R2 flush reads 0");
    wr(A(1,2,0), 32'h2);
    cyc(); push(5, 32'h1, "R10 R8 alias flush OUT0");

    cyc();
    cyc();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule